// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped First-Level Cache

This block sits beside a direct-mapped first-level cache. A direct-mapped array loses lines whenever several active addresses fall into the same set. Every line that the first-level cache throws out is placed in this small, fully associative buffer. When the first-level cache misses, it probes the buffer before it sends any request to the next level. On a hit, the buffered line goes back to the first-level cache. In the same cycle, the line that the first-level cache displaces from that set takes the freed slot, so the two lines trade places. This gives a few busy sets some extra associativity without widening the main array.

The buffer holds a parameterised number of lines (4 or 8). Each line carries its full line address, its data, a valid flag and a dirty flag. When a new line arrives and no slot is free, a slot is chosen in round-robin order. A dirty line pushed out that way leaves on a one-cycle writeback port toward the next level.

Top module: `victim_cache`

## Requirements
- R1: A probe (lookupValid high) compares lookupAddr with the stored address of every valid slot in the same cycle. lookupHit, lookupIndex (slot number, 0-based), lookupData and lookupDirty are combinational outputs of that compare.
- R2: After reset every slot is invalid: no probe hits and wbValid is low.
- R3: An eviction (evictValid high) with no probe hit in the same cycle is written into the lowest-numbered invalid slot when one exists. From the next cycle the line hits with the supplied data and dirty flag.
- R4: With all slots valid, such an eviction overwrites the slot named by a replacement pointer. The pointer is 0 after reset, advances by one per overwrite of a full buffer, and wraps from ENTRIES-1 to 0.
- R5: Overwriting a valid dirty slot raises wbValid for exactly the one cycle after the writing edge, with that slot's old address on wbAddr and old data on wbData. Overwriting a clean slot raises nothing.
- R6: A probe hit in the same cycle as an eviction returns the hit slot and writes the evicted line into that same slot with its own dirty flag. It causes no writeback and leaves the replacement pointer unchanged.
- R7: A probe hit with no eviction in that cycle frees the hit slot, so the same address misses afterwards.
- R8: A probe miss leaves every stored line unchanged. An eviction in the same cycle is handled as in R3 and R4.
- R9: A dirty line that is swapped out to the first-level cache and back keeps its dirty flag. When it is finally displaced, its data appears on the writeback port exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evictValid | input | 1 | A line discarded by the first-level cache is offered |
| evictAddr | input | ADDR_W | Line address of the discarded line |
| evictData | input | LINE_W | Data of the discarded line |
| evictDirty | input | 1 | Discarded line differs from the next level |
| lookupValid | input | 1 | Probe after a first-level miss |
| lookupAddr | input | ADDR_W | Line address being probed |
| lookupHit | output | 1 | Probe found a valid matching slot |
| lookupIndex | output | $clog2(ENTRIES) | Slot number of the hit |
| lookupData | output | LINE_W | Data of the hit slot |
| lookupDirty | output | 1 | Dirty flag of the hit slot |
| wbValid | output | 1 | Dirty line displaced, one-cycle pulse |
| wbAddr | output | ADDR_W | Line address of the displaced dirty line |
| wbData | output | LINE_W | Data of the displaced dirty line |

## Verification
The properties assume that the buffer and the first-level cache stay exclusive. An evicted line is never already held in the buffer, so at most one slot can match a probe. They also assume that the line handed over during a swap comes from a different address than the one being probed. The stimulus keeps to both rules: every inserted address is either fresh or was taken out of the buffer by an earlier hit, and the swap sequence alternates two distinct lines that collide in one first-level set.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Widest slot number the buffer supports (up to 8 slots).
  localparam int VC_IDX_W = 3;

  // Strobes from the control to the storage datapath for one cycle.
  typedef struct packed {
    logic                fill;    // write the evicted line into slotIdx
    logic                drop;    // clear the valid flag of slotIdx
    logic                spill;   // capture slotIdx contents for writeback
    logic [VC_IDX_W-1:0] slotIdx; // slot the strobes act on
  } vcStrobe_t;

endpackage

// File: rtl/vc_datapath.sv
module vc_datapath
  import vc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vcStrobe_t         strobe,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [LINE_W-1:0] evictData,
  input  logic              evictDirty,
  output logic [ENTRIES-1:0] hitVec,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] dirtyVec,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [LINE_W-1:0] hitData,
  output logic              hitDirty,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [LINE_W-1:0] wbData
);

  logic [ADDR_W-1:0] addrArr [ENTRIES];
  logic [LINE_W-1:0] dataArr [ENTRIES];

  // One storage slot per entry, each with its own match comparator.
  for (genvar e = 0; e < ENTRIES; e++) begin : gSlot
    logic              sel;
    logic              vQ;
    logic              dQ;
    logic [ADDR_W-1:0] aQ;
    logic [LINE_W-1:0] lQ;

    assign sel = (strobe.slotIdx == VC_IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vQ <= 1'b0;
        dQ <= 1'b0;
      end else if (sel && strobe.fill) begin
        vQ <= 1'b1;
        dQ <= evictDirty;
      end else if (sel && strobe.drop) begin
        vQ <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && strobe.fill) begin
        aQ <= evictAddr;
        lQ <= evictData;
      end
    end

    assign validVec[e] = vQ;
    assign dirtyVec[e] = dQ;
    assign addrArr[e]  = aQ;
    assign dataArr[e]  = lQ;
    assign hitVec[e]   = lookupValid && vQ && (aQ == lookupAddr);
  end

  // Hit encoding and read-out, plus selection of the slot to spill.
  logic [ADDR_W-1:0] spillAddr;
  logic [LINE_W-1:0] spillData;

  always_comb begin
    hitIdx    = '0;
    hitData   = '0;
    hitDirty  = 1'b0;
    spillAddr = '0;
    spillData = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hitVec[e]) begin
        hitIdx   = hitIdx | IDX_W'(e);
        hitData  = hitData | dataArr[e];
        hitDirty = hitDirty | dirtyVec[e];
      end
      if (strobe.slotIdx == VC_IDX_W'(e)) begin
        spillAddr = addrArr[e];
        spillData = dataArr[e];
      end
    end
  end

  // Writeback register: holds the displaced line for one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wbValid <= 1'b0;
    else        wbValid <= strobe.spill;
  end

  always_ff @(posedge clk) begin
    if (strobe.spill) begin
      wbAddr <= spillAddr;
      wbData <= spillData;
    end
  end

endmodule

// File: rtl/vc_control.sv
module vc_control
  import vc_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evictValid,
  input  logic [ENTRIES-1:0] hitVec,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] dirtyVec,
  input  logic [IDX_W-1:0]   hitIdx,
  output vcStrobe_t          strobe
);

  logic             anyHit;
  logic             anyFree;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] ptrQ;
  logic             advance;

  assign anyHit  = |hitVec;
  assign anyFree = ~&validVec;

  // Lowest-numbered invalid slot.
  always_comb begin
    freeIdx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!validVec[e]) freeIdx = IDX_W'(e);
    end
  end

  assign advance = evictValid && !anyHit && !anyFree;

  // Round-robin replacement pointer, moves only when a full buffer is overwritten.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrQ <= '0;
    end else if (advance) begin
      if (ptrQ == IDX_W'(ENTRIES - 1)) ptrQ <= '0;
      else                             ptrQ <= ptrQ + 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    if (anyHit) begin
      strobe.slotIdx = VC_IDX_W'(hitIdx);
      if (evictValid) strobe.fill = 1'b1;
      else            strobe.drop = 1'b1;
    end else if (evictValid) begin
      strobe.fill = 1'b1;
      if (anyFree) begin
        strobe.slotIdx = VC_IDX_W'(freeIdx);
      end else begin
        strobe.slotIdx = VC_IDX_W'(ptrQ);
        strobe.spill   = dirtyVec[ptrQ];
      end
    end
  end

endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [LINE_W-1:0] evictData,
  input  logic              evictDirty,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupHit,
  output logic [IDX_W-1:0]  lookupIndex,
  output logic [LINE_W-1:0] lookupData,
  output logic              lookupDirty,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [LINE_W-1:0] wbData
);

  vcStrobe_t          strobe;
  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] dirtyVec;

  vc_control #(.ENTRIES(ENTRIES)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .evictValid (evictValid),
    .hitVec     (hitVec),
    .validVec   (validVec),
    .dirtyVec   (dirtyVec),
    .hitIdx     (lookupIndex),
    .strobe     (strobe)
  );

  vc_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) uData (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .lookupValid (lookupValid),
    .lookupAddr  (lookupAddr),
    .evictAddr   (evictAddr),
    .evictData   (evictData),
    .evictDirty  (evictDirty),
    .hitVec      (hitVec),
    .validVec    (validVec),
    .dirtyVec    (dirtyVec),
    .hitIdx      (lookupIndex),
    .hitData     (lookupData),
    .hitDirty    (lookupDirty),
    .wbValid     (wbValid),
    .wbAddr      (wbAddr),
    .wbData      (wbData)
  );

  assign lookupHit = |hitVec;

endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evictValid,
  input logic [ADDR_W-1:0] evictAddr,
  input logic [LINE_W-1:0] evictData,
  input logic              evictDirty,
  input logic              lookupValid,
  input logic [ADDR_W-1:0] lookupAddr,
  input logic              lookupHit,
  input logic [IDX_W-1:0]  lookupIndex,
  input logic [LINE_W-1:0] lookupData,
  input logic              lookupDirty,
  input logic              wbValid
);

  logic           pastOk;
  logic [IDX_W:0] occQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastOk <= 1'b0;
    else        pastOk <= 1'b1;
  end

  // Independent count of occupied slots, seen from the ports.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occQ <= '0;
    end else if (evictValid && !lookupHit && occQ != (IDX_W+1)'(ENTRIES)) begin
      occQ <= occQ + 1'b1;
    end else if (lookupHit && !evictValid) begin
      occQ <= occQ - 1'b1;
    end
  end

  assert_empty_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pastOk |-> (!lookupHit && !wbValid));

  assert_hit_needs_probe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lookupHit |-> lookupValid);

  assert_insert_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && $past(evictValid && !lookupHit) && lookupValid && lookupAddr == $past(evictAddr))
    |-> (lookupHit && lookupData == $past(evictData) && lookupDirty == $past(evictDirty)));

  assert_spill_only_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && wbValid) |-> ($past(evictValid && !lookupHit) && $past(occQ) == (IDX_W+1)'(ENTRIES)));

  assert_swap_same_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && $past(lookupHit && evictValid) && lookupValid && lookupAddr == $past(evictAddr))
    |-> (lookupHit && lookupIndex == $past(lookupIndex) && lookupDirty == $past(evictDirty)));

  assert_swap_no_spill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lookupHit |=> !wbValid);

  assert_drop_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && $past(lookupHit && !evictValid) && lookupValid && lookupAddr == $past(lookupAddr))
    |-> !lookupHit);

endmodule

bind victim_cache vc_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) uChecker (
  .clk         (clk),
  .rst_n       (rst_n),
  .evictValid  (evictValid),
  .evictAddr   (evictAddr),
  .evictData   (evictData),
  .evictDirty  (evictDirty),
  .lookupValid (lookupValid),
  .lookupAddr  (lookupAddr),
  .lookupHit   (lookupHit),
  .lookupIndex (lookupIndex),
  .lookupData  (lookupData),
  .lookupDirty (lookupDirty),
  .wbValid     (wbValid)
);

// File: tb/victim_cache_test.sv
`timescale 1ns/1ps
module victim_cache_test;

  localparam int N  = 4;
  localparam int AW = 26;
  localparam int LW = 64;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          evictValid;
  logic [AW-1:0] evictAddr;
  logic [LW-1:0] evictData;
  logic          evictDirty;
  logic          lookupValid;
  logic [AW-1:0] lookupAddr;
  logic          lookupHit;
  logic [IW-1:0] lookupIndex;
  logic [LW-1:0] lookupData;
  logic          lookupDirty;
  logic          wbValid;
  logic [AW-1:0] wbAddr;
  logic [LW-1:0] wbData;

  victim_cache uut (
    .clk(clk), .rst_n(rst_n),
    .evictValid(evictValid), .evictAddr(evictAddr), .evictData(evictData), .evictDirty(evictDirty),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .lookupHit(lookupHit), .lookupIndex(lookupIndex), .lookupData(lookupData), .lookupDirty(lookupDirty),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  int xSpills = 0;
  bit done = 1'b0;

  localparam logic [AW-1:0] X_ADDR = 26'h0300;
  localparam logic [AW-1:0] Y_ADDR = 26'h1300;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Scoreboard of expected writebacks.
  typedef struct {
    logic [AW-1:0] a;
    logic [LW-1:0] d;
    int            c;
  } wbExp_t;
  wbExp_t expQ[$];

  // Reference contents, kept from the requirements.
  bit            mValid [N];
  bit            mDirty [N];
  logic [AW-1:0] mAddr  [N];
  logic [LW-1:0] mData  [N];
  int            mPtr = 0;

  function automatic logic [LW-1:0] mkData(input logic [AW-1:0] a, input int salt);
    return {6'h2a, a, 32'(salt) ^ 32'hC0DE_0000};
  endfunction

  // Driver: one cycle of stimulus, immediate checks of the probe reply,
  // and expected writebacks pushed to the scoreboard.
  task automatic op(input bit lv, input logic [AW-1:0] la,
                    input bit ev, input logic [AW-1:0] ea, input int salt, input bit edt,
                    input string tag);
    int hi;
    int slot;
    @(negedge clk);
    lookupValid = lv;  lookupAddr = la;
    evictValid  = ev;  evictAddr  = ea;
    evictData   = mkData(ea, salt);
    evictDirty  = edt;
    #2;
    hi = -1;
    if (lv) for (int k = 0; k < N; k++) if (mValid[k] && mAddr[k] == la) hi = k;
    check(lookupHit == (hi >= 0), tag, "hit", LW'(lookupHit), LW'(hi >= 0));
    if (hi >= 0 && lookupHit) begin
      check(lookupIndex == IW'(hi), tag, "index", LW'(lookupIndex), LW'(hi));
      check(lookupData == mData[hi], tag, "data", lookupData, mData[hi]);
      check(lookupDirty == mDirty[hi], tag, "dirty", LW'(lookupDirty), LW'(mDirty[hi]));
    end
    if (hi >= 0) begin
      if (ev) begin
        mAddr[hi] = ea; mData[hi] = evictData; mDirty[hi] = edt;
      end else begin
        mValid[hi] = 1'b0;
      end
    end else if (ev) begin
      slot = -1;
      for (int k = N - 1; k >= 0; k--) if (!mValid[k]) slot = k;
      if (slot < 0) begin
        slot = mPtr;
        if (mDirty[slot]) expQ.push_back('{a: mAddr[slot], d: mData[slot], c: cycleCnt + 1});
        mPtr = (mPtr + 1) % N;
      end
      mValid[slot] = 1'b1; mAddr[slot] = ea; mData[slot] = evictData; mDirty[slot] = edt;
    end
  endtask

  task automatic idle();
    op(1'b0, '0, 1'b0, '0, 0, 1'b0, "idle");
  endtask

  // Monitor: compares each writeback pulse against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (expQ.size() > 0 && expQ[0].c < cycleCnt) begin
        check(1'b0, "R5", "missing writeback", '0, LW'(expQ[0].a));
        void'(expQ.pop_front());
      end
      if (wbValid) begin
        if (wbAddr == X_ADDR) xSpills++;
        if (expQ.size() == 0) begin
          check(1'b0, "R5", "unexpected writeback", LW'(wbAddr), '0);
        end else begin
          wbExp_t e;
          e = expQ.pop_front();
          check(wbAddr == e.a, "R5", "wb addr", LW'(wbAddr), LW'(e.a));
          check(wbData == e.d, "R5", "wb data", wbData, e.d);
          check(cycleCnt == e.c, "R5", "wb cycle", LW'(cycleCnt), LW'(e.c));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin mValid[k] = 1'b0; mDirty[k] = 1'b0; end
    rst_n = 1'b0;
    evictValid = 1'b0; evictAddr = '0; evictData = '0; evictDirty = 1'b0;
    lookupValid = 1'b0; lookupAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2: empty after reset
    op(1'b1, 26'h0100, 1'b0, '0, 0, 1'b0, "R2");
    check(wbValid == 1'b0, "R2", "wbValid after reset", LW'(wbValid), '0);

    // R3: fill free slots in order, odd lines dirty
    for (int k = 0; k < N; k++) op(1'b0, '0, 1'b1, 26'h0100 + AW'(k), k, k[0], "R3");
    // R1: parallel compare finds each line at its slot
    for (int k = 0; k < N; k++) op(1'b1, 26'h0100 + AW'(k), 1'b0, '0, 0, 1'b0, "R1");
    // The probes above dropped the lines (R7); refill them
    for (int k = 0; k < N; k++) op(1'b0, '0, 1'b1, 26'h0100 + AW'(k), k, k[0], "R3");

    // R8: a probe miss changes nothing
    op(1'b1, 26'h0999, 1'b0, '0, 0, 1'b0, "R8");
    op(1'b1, 26'h0999, 1'b0, '0, 0, 1'b0, "R8");
    // R8: miss with concurrent eviction is a normal insertion (full: replaces slot 0, clean)
    op(1'b1, 26'h0998, 1'b1, 26'h0200, 10, 1'b1, "R8");

    // R4/R5: further insertions walk the pointer and spill dirty slots
    for (int k = 1; k < 6; k++) op(1'b0, '0, 1'b1, 26'h0200 + AW'(k), 10 + k, k[0], "R4");

    // R9/R6: dirty X into the buffer, then ping-pong X and Y through one L1 set
    op(1'b0, '0, 1'b1, X_ADDR, 77, 1'b1, "R9");
    for (int k = 0; k < 6; k++) begin
      if (k[0] == 1'b0) op(1'b1, X_ADDR, 1'b1, Y_ADDR, 88, 1'b0, "R6");
      else              op(1'b1, Y_ADDR, 1'b1, X_ADDR, 77, 1'b1, "R6");
    end
    // X is back in the buffer, dirty; push it out with clean lines
    for (int k = 0; k < N; k++) op(1'b0, '0, 1'b1, 26'h0400 + AW'(k), 40 + k, 1'b0, "R9");

    // R7: a hit without eviction frees the slot
    op(1'b1, 26'h0402, 1'b0, '0, 0, 1'b0, "R7");
    op(1'b1, 26'h0402, 1'b0, '0, 0, 1'b0, "R7");
    // R3: the freed slot is reused ahead of the pointer
    op(1'b0, '0, 1'b1, 26'h0500, 50, 1'b1, "R3");
    op(1'b1, 26'h0500, 1'b1, 26'h0501, 51, 1'b0, "R3");
    // R4: full again, one more replacement
    op(1'b0, '0, 1'b1, 26'h0600, 60, 1'b0, "R4");
    op(1'b1, 26'h0600, 1'b0, '0, 0, 1'b0, "R4");

    repeat (3) idle();
    check(expQ.size() == 0, "R5", "pending writebacks", LW'(expQ.size()), '0);
    check(xSpills == 1, "R9", "dirty line written back", LW'(xSpills), LW'(1));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule